// File: doc/BRIEF.md
# Descriptor-Count Interrupt Coalescing Controller

This block sits between the receive and send completion paths of a network engine and the host. It counts completed buffer descriptors for each direction. It decides when the host must get a fresh status block and when the host must get an interrupt. Each direction has two count thresholds. One applies while the interrupt is unmasked (the normal state). The other applies after software has acknowledged the interrupt (the masked state).

In the normal state, when a count reaches its threshold, the block requests a status-block write. The interrupt rises once that write is acknowledged. Software enters the masked state by writing a non-zero value to the mailbox. In the masked state the interrupt is held low, and the masked-state thresholds only request status-block writes. A mailbox write of zero returns the block to the normal state. Only one status-write request is outstanding at a time. Any trigger that occurs while a request is pending is served by that request.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset, `stat_req` and `irq_out` are low, the block is in the normal state, both counts are zero and all four thresholds are zero, so completions raise no request.
- R2: Each cycle with `rx_done` (or `tx_done`) high adds one to the receive (or send) count. In the normal state, when a count is greater than or equal to its non-zero normal threshold, `stat_req` rises on the clock edge after the edge at which the count reached the threshold.
- R3: In the normal state, the edge at which `stat_ack` is sampled high with `stat_req` high drops `stat_req` and raises `irq_out`. `irq_out` never rises at any other time.
- R4: A write of a non-zero value to the mailbox (address 4) enters the masked state and clears `irq_out` on that edge. `irq_out` stays low for as long as the block is masked.
- R5: In the masked state, a count reaching its non-zero masked threshold raises `stat_req` with the same timing as R2. Acknowledging that request leaves `irq_out` low.
- R6: The normal thresholds are ignored in the masked state, and the masked thresholds are ignored in the normal state.
- R7: A mailbox write of zero returns the block to the normal state without raising `irq_out`. The next acknowledged normal-state request raises it.
- R8: The acknowledge edge restarts both counts from zero. A completion pulse in the acknowledge cycle counts as the first descriptor after the restart.
- R9: A threshold of zero disables that trigger, whatever the count is.
- R10: `stat_req` stays high until it is acknowledged and drops on the acknowledge edge. Triggers that occur while it is pending are merged into it, so no further request follows from them.
- R11: The receive and send counts and thresholds are independent, and either one can trigger a request.
- R12: The register addresses are: 0 receive normal threshold, 1 send normal threshold, 2 receive masked threshold, 3 send masked threshold, 4 mailbox. A threshold write takes the low `CNT_W` bits of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | One receive descriptor completed this cycle |
| tx_done | input | 1 | One send descriptor completed this cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | DATA_W | Register write data |
| stat_req | output | 1 | Status-block write request, held until acknowledged |
| stat_ack | input | 1 | Status-block write done |
| irq_out | output | 1 | Interrupt to the host |

## Verification
The hardest case to reach is a completion pulse that lands in the same cycle as the acknowledge. To get there, the stimulus must first build a masked-state request and then drive the pulse and the acknowledge together. After that, one more pulse must be enough to raise a new request. This shows that the count restarted at one and not at zero. A scoreboard records each request and interrupt edge that the stimulus is expected to cause. Any extra edge, including one caused by merged triggers or by the wrong threshold set, is reported as unexpected.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned NUM_CH  = 2;
   localparam int unsigned CH_RX   = 0;
   localparam int unsigned CH_TX   = 1;
   localparam int unsigned NUM_MODE = 2;   // 0 normal, 1 masked
   localparam int unsigned ADDR_W  = 3;
   // threshold address = mode * NUM_CH + channel; mailbox follows them
   localparam logic [ADDR_W-1:0] A_MBOX = ADDR_W'(NUM_MODE * NUM_CH);
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [DATA_W-1:0]              wdata,
   output logic [NUM_CH-1:0][CNT_W-1:0]   thr_norm,
   output logic [NUM_CH-1:0][CNT_W-1:0]   thr_mask,
   output logic                           masked,
   output logic                           masked_nxt,
   output logic                           mbox_set
);
   if (CNT_W > DATA_W) begin : g_bad_width
      $error("irqc_regs: CNT_W must not exceed DATA_W");
   end

   logic mbox_wr;
   logic mbox_nz;

   assign mbox_wr    = we && (addr == A_MBOX);
   assign mbox_nz    = (wdata != '0);
   assign mbox_set   = mbox_wr && mbox_nz;
   assign masked_nxt = mbox_wr ? mbox_nz : masked;

   for (genvar m = 0; m < NUM_MODE; m++) begin : g_mode
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(m * NUM_CH + c);
         logic [CNT_W-1:0] thr_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               thr_q <= '0;
            end else if (we && (addr == MY_ADDR)) begin
               thr_q <= wdata[CNT_W-1:0];
            end
         end

         if (m == 0) begin : g_n
            assign thr_norm[c] = thr_q;
         end else begin : g_m
            assign thr_mask[c] = thr_q;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         masked <= 1'b0;
      end else begin
         masked <= masked_nxt;
      end
   end

   AST_MBOX_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
      mbox_set |=> masked);  // R4
   AST_MBOX_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (mbox_wr && !mbox_nz) |=> !masked);  // R7
endmodule

// File: rtl/irqc_counter.sv
module irqc_counter #(
   parameter int unsigned CNT_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   input  logic             masked,
   input  logic [CNT_W-1:0] thr_norm,
   input  logic [CNT_W-1:0] thr_mask,
   output logic [CNT_W-1:0] count,
   output logic             hit
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] thr_sel;
   logic [CNT_W-1:0] cnt_up;

   if (CNT_W < 2) begin : g_bad_width
      $error("irqc_counter: CNT_W must be at least 2");
   end

   if (SATURATE) begin : g_sat
      assign cnt_up = (count == CNT_MAX) ? count : count + 1'b1;
   end else begin : g_wrap
      assign cnt_up = count + 1'b1;
   end

   assign thr_sel = masked ? thr_mask : thr_norm;
   assign hit     = (thr_sel != '0) && (count >= thr_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= inc ? CNT_W'(1) : '0;
      end else if (inc) begin
         count <= cnt_up;
      end
   end

   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count <= CNT_W'(1)));  // R8
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(count));  // R2
endmodule

// File: rtl/irqc_req_ctrl.sv
module irqc_req_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic any_hit,
   input  logic masked,
   input  logic masked_nxt,
   input  logic mbox_set,
   input  logic stat_ack,
   output logic stat_req,
   output logic served,
   output logic irq
);
   assign served = stat_req && stat_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_req <= 1'b0;
      end else if (served) begin
         stat_req <= 1'b0;
      end else if (any_hit) begin
         stat_req <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else if (mbox_set) begin
         irq <= 1'b0;
      end else if (served && !masked_nxt) begin
         irq <= 1'b1;
      end
   end

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      masked |-> !irq);  // R4
   AST_IRQ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(stat_req && stat_ack));  // R3
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_req && !stat_ack) |=> stat_req);  // R10
   AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_req && stat_ack) |=> !stat_req);  // R10
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned DATA_W   = 32,
   parameter bit          SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_done,
   input  logic              tx_done,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              stat_req,
   input  logic              stat_ack,
   output logic              irq_out
);
   logic [NUM_CH-1:0][CNT_W-1:0] thr_norm;
   logic [NUM_CH-1:0][CNT_W-1:0] thr_mask;
   logic [NUM_CH-1:0][CNT_W-1:0] count;
   logic [NUM_CH-1:0]            done_vec;
   logic [NUM_CH-1:0]            hit_vec;
   logic                         masked;
   logic                         masked_nxt;
   logic                         mbox_set;
   logic                         served;

   assign done_vec[CH_RX] = rx_done;
   assign done_vec[CH_TX] = tx_done;

   irqc_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .addr      (cfg_addr),
      .wdata     (cfg_wdata),
      .thr_norm  (thr_norm),
      .thr_mask  (thr_mask),
      .masked    (masked),
      .masked_nxt(masked_nxt),
      .mbox_set  (mbox_set)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_cnt
      irqc_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .inc     (done_vec[c]),
         .clr     (served),
         .masked  (masked),
         .thr_norm(thr_norm[c]),
         .thr_mask(thr_mask[c]),
         .count   (count[c]),
         .hit     (hit_vec[c])
      );
   end

   irqc_req_ctrl u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_hit   (|hit_vec),
      .masked    (masked),
      .masked_nxt(masked_nxt),
      .mbox_set  (mbox_set),
      .stat_ack  (stat_ack),
      .stat_req  (stat_req),
      .served    (served),
      .irq       (irq_out)
   );

   AST_REQ_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_req) |-> $past(|hit_vec));  // R9
   AST_ACK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      served |=> (count[CH_RX] <= CNT_W'(1)) && (count[CH_TX] <= CNT_W'(1)));  // R8
endmodule

// File: tb/tb_irq_coalesce_ctrl.sv
`timescale 1ns/1ps
module tb_irq_coalesce_ctrl;
   localparam int unsigned DATA_W = 32;
   localparam logic [2:0] A_RXN = 3'd0, A_TXN = 3'd1, A_RXM = 3'd2, A_TXM = 3'd3, A_MB = 3'd4;

   typedef enum int {EV_REQ, EV_IRQ} ev_e;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rx_done = 1'b0;
   logic              tx_done = 1'b0;
   logic              cfg_we = 1'b0;
   logic [2:0]        cfg_addr = '0;
   logic [DATA_W-1:0] cfg_wdata = '0;
   logic              stat_ack = 1'b0;
   logic              stat_req;
   logic              irq_out;

   int n_chk = 0;
   int n_fail = 0;
   ev_e   exp_q[$];
   string tag_q[$];
   logic  prev_req = 1'b0;
   logic  prev_irq = 1'b0;

   always #2.5 clk = ~clk;

   irq_coalesce_ctrl dut (
      .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .tx_done(tx_done),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .stat_req(stat_req), .stat_ack(stat_ack), .irq_out(irq_out)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic expect_ev(input ev_e e, input string rq);
      exp_q.push_back(e);
      tag_q.push_back(rq);
   endtask

   // monitor: every rising edge of stat_req or irq_out must match the scoreboard
   task automatic seen(input ev_e e);
      if (exp_q.size() == 0) begin
         chk(1'b0, "R10 unexpected event", int'(e), -1);
      end else begin
         ev_e   x = exp_q.pop_front();
         string t = tag_q.pop_front();
         chk(x == e, t, int'(e), int'(x));
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (stat_req && !prev_req) seen(EV_REQ);
         if (irq_out && !prev_irq) seen(EV_IRQ);
      end
      prev_req = stat_req;
      prev_irq = irq_out;
   end

   task automatic wr(input logic [2:0] a, input int unsigned d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = DATA_W'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse(input bit is_tx, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (is_tx) tx_done = 1'b1; else rx_done = 1'b1;
      end
      @(negedge clk);
      rx_done = 1'b0; tx_done = 1'b0;
   endtask

   task automatic ack(input bit with_tx);
      @(negedge clk);
      stat_ack = 1'b1; tx_done = with_tx;
      @(negedge clk);
      stat_ack = 1'b0; tx_done = 1'b0;
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(5.0 * 50000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(stat_req == 1'b0, "R1 req after reset", int'(stat_req), 0);
      chk(irq_out == 1'b0, "R1 irq after reset", int'(irq_out), 0);

      // R1 / R9: thresholds zero after reset, no trigger
      pulse(1'b0, 2);
      @(negedge clk);
      chk(stat_req == 1'b0, "R1 zero thresholds", int'(stat_req), 0);

      // R2 / R12: receive normal threshold 3, count already 2
      wr(A_RXN, 3);
      chk(stat_req == 1'b0, "R2 below threshold", int'(stat_req), 0);
      expect_ev(EV_REQ, "R2 req event");
      pulse(1'b0, 1);
      chk(stat_req == 1'b0, "R2 req not early", int'(stat_req), 0);
      @(negedge clk);
      chk(stat_req == 1'b1, "R2 req rises", int'(stat_req), 1);

      // R10: merged triggers while pending
      pulse(1'b0, 2);
      chk(stat_req == 1'b1, "R10 req held", int'(stat_req), 1);
      expect_ev(EV_IRQ, "R3 irq event");
      ack(1'b0);
      chk(stat_req == 1'b0, "R3 req drops on ack", int'(stat_req), 0);
      chk(irq_out == 1'b1, "R3 irq rises on ack", int'(irq_out), 1);
      repeat (3) @(negedge clk);
      chk(stat_req == 1'b0, "R10 merged no re-request", int'(stat_req), 0);

      // R4: enter masked state
      wr(A_MB, 1);
      chk(irq_out == 1'b0, "R4 irq cleared by mailbox", int'(irq_out), 0);
      wr(A_TXM, 2);

      // R6 / R9: normal rx threshold ignored, masked rx threshold zero
      pulse(1'b0, 5);
      @(negedge clk);
      chk(stat_req == 1'b0, "R6 normal thr ignored when masked", int'(stat_req), 0);

      // R5 / R11: send masked threshold triggers
      expect_ev(EV_REQ, "R5 masked req event");
      pulse(1'b1, 2);
      @(negedge clk);
      chk(stat_req == 1'b1, "R11 send count triggers", int'(stat_req), 1);
      ack(1'b0);
      chk(irq_out == 1'b0, "R5 irq stays low after masked ack", int'(irq_out), 0);
      chk(stat_req == 1'b0, "R5 req drops", int'(stat_req), 0);

      // R8: pulse in the ack cycle counts as one
      expect_ev(EV_REQ, "R8 first req");
      pulse(1'b1, 2);
      @(negedge clk);
      chk(stat_req == 1'b1, "R8 setup req", int'(stat_req), 1);
      ack(1'b1);
      chk(stat_req == 1'b0, "R8 req drops", int'(stat_req), 0);
      expect_ev(EV_REQ, "R8 restart req");
      pulse(1'b1, 1);
      chk(stat_req == 1'b0, "R8 req timing after restart", int'(stat_req), 0);
      @(negedge clk);
      chk(stat_req == 1'b1, "R8 count restarted at one", int'(stat_req), 1);
      ack(1'b0);
      chk(irq_out == 1'b0, "R4 irq low while masked", int'(irq_out), 0);

      // R7: back to normal state
      wr(A_MB, 0);
      chk(irq_out == 1'b0, "R7 unmask does not raise irq", int'(irq_out), 0);

      // R9 / R6: send normal threshold zero; masked send threshold ignored
      pulse(1'b1, 4);
      @(negedge clk);
      chk(stat_req == 1'b0, "R9 zero threshold disables", int'(stat_req), 0);

      expect_ev(EV_REQ, "R7 normal req event");
      expect_ev(EV_IRQ, "R7 irq event after unmask");
      pulse(1'b0, 3);
      @(negedge clk);
      chk(stat_req == 1'b1, "R7 normal req", int'(stat_req), 1);
      ack(1'b0);
      chk(irq_out == 1'b1, "R7 irq returns", int'(irq_out), 1);

      wr(A_MB, 5);
      chk(irq_out == 1'b0, "R4 irq cleared again", int'(irq_out), 0);
      repeat (4) @(negedge clk);
      chk(irq_out == 1'b0, "R4 irq stays low", int'(irq_out), 0);
      chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
      report();
   end
endmodule